// File: doc/BRIEF.md
# Two-Port Lane-Enabled Pipelined RAM

This block is a synchronous static RAM with two symmetric access ports, A and B. Each port has its own clock and its own synchronous reset, and the two ports work fully independently of each other. Each port registers its address, write data, lane enables and control inputs on its rising clock edge. In the following cycle the port performs either a write or a read. Read data is held in an output register, so a read address sampled on one edge yields data after the next edge of the same clock.

A word consists of byte lanes of nine bits. With the defaults there are two lanes: lane 0 is bits 8:0 and lane 1 is bits 17:9. Each lane has an active-low enable, which applies to writes and to reads alike.

A port takes part in an access only when it is selected. Selection needs two chip selects of opposite polarity: the active-low select must be low and the active-high select must be high. The output enable is asynchronous. Output lanes are not modelled as tri-state pins. Each lane instead has a drive flag, and a lane whose flag is low presents zeros; this stands in for high impedance. After the port has been deselected, it must see two consecutive selected edges before its reads drive the outputs again.

Both ports may address any word at the same time. A word written through one port can be read through the other.

Top module: `dp_lane_ram`

## Requirements
- R1: A port is selected only when `x_cs_n` is 0 and `x_cs` is 1 at its sampling edge. A deselected cycle writes nothing, and it leaves both lane drive flags at 0 after the following edge.
- R2: A selected cycle with `x_rnw` = 0 writes the addressed word one edge after sampling. It changes only the lanes whose `x_lane_en_n` bit is 0 (bit 0 selects data bits 8:0, bit 1 selects bits 17:9). The other lanes keep their stored contents.
- R3: When a read address is sampled on edge k, its data appears on `x_rdata` after edge k+1 and stays there until the next edge. A write on a port is visible to a read on the same port that is sampled on the next edge.
- R4: During a driven read, a lane is driven (`x_lane_drv` bit = 1) only if its enable bit was 0. An undriven lane shows all zeros on its slice of `x_rdata`.
- R5: While `x_oe_n` is 1, both drive flags are 0 and `x_rdata` is all zeros. This takes effect at once, without waiting for a clock edge, and the outputs return as soon as `x_oe_n` goes back to 0.
- R6: A read drives the outputs only if the port was selected at its sampling edge and at the edge just before it. The first selected read after a deselected edge therefore drives nothing.
- R7: A word written through one port is returned by a later read through the other port. Writes to different addresses issued on both ports in the same period both take effect.
- R8: When both ports write the same address in the same period, the content of that one word is undefined. Every other word keeps its value.
- R9: After synchronous reset, the port's drive flags are 0. The reactivation history is cleared, so two selected edges are needed before the first read drives.
- R10: A write cycle drives no lane after its access edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst | input | 1 | Port A synchronous reset, active high |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_cs | input | 1 | Port A chip select, active high |
| a_rnw | input | 1 | Port A access direction: 1 read, 0 write |
| a_lane_en_n | input | LANES | Port A lane enables, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_rdata | output | LANES*LANE_W | Port A read data (zero in undriven lanes) |
| a_lane_drv | output | LANES | Port A per-lane drive flags |
| b_clk | input | 1 | Port B clock |
| b_rst | input | 1 | Port B synchronous reset, active high |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_cs | input | 1 | Port B chip select, active high |
| b_rnw | input | 1 | Port B access direction: 1 read, 0 write |
| b_lane_en_n | input | LANES | Port B lane enables, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_rdata | output | LANES*LANE_W | Port B read data (zero in undriven lanes) |
| b_lane_drv | output | LANES | Port B per-lane drive flags |

## Verification
The hardest case to reach is two writes in the same period, one on each port, on unrelated clocks.

The stimulus launches the two port drivers in parallel, so their accesses overlap in time. It does this once for distinct addresses and once for a shared address that sits between two words written beforehand. Both ports then read back the neighbouring words after several idle edges; the idle edges guarantee that every commit on either clock has taken place.

Reactivation is reached by issuing both deselect encodings just before a read. The bench then expects one undriven read followed by a driven one.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

  // What an access stage does with the request it captured
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_t;

  // Both chip selects must agree for the port to take part
  function automatic logic port_selected(input logic cs_n, input logic cs);
    return !cs_n && cs;
  endfunction

endpackage

// File: rtl/dpr_port_ctrl.sv
`timescale 1ns/1ps
module dpr_port_ctrl
  import dpr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int LANES    = 2,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cs_n,
  input  logic                     cs,
  input  logic                     rnw,
  input  logic [LANES-1:0]         lane_en_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output logic [ADDR_W-1:0]        acc_addr,
  output logic [LANES*LANE_W-1:0]  acc_wdata,
  output logic [LANES-1:0]         wr_stb,
  output logic                     rd_go,
  output logic [LANES-1:0]         rd_lane_n
);

  localparam int DW = LANES * LANE_W;
  localparam int CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] WAKE_LIM = CW'(WAKE_CYC);

  acc_kind_t        kind_q;
  logic [LANES-1:0] lane_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]    wdata_q;
  logic [CW-1:0]    wake_q;
  logic             sel;

  assign sel = port_selected(cs_n, cs);

  // Input register stage: everything except output enable is captured here
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q   <= ACC_NONE;
      lane_n_q <= '1;
      addr_q   <= '0;
      wdata_q  <= '0;
      wake_q   <= '0;
    end else begin
      if (!sel)      kind_q <= ACC_NONE;
      else if (rnw)  kind_q <= ACC_READ;
      else           kind_q <= ACC_WRITE;
      lane_n_q <= lane_en_n;
      addr_q   <= addr;
      wdata_q  <= wdata;
      // consecutive selected edges, saturating at the reactivation count
      if (!sel)                  wake_q <= '0;
      else if (wake_q != WAKE_LIM) wake_q <= wake_q + 1'b1;
    end
  end

  assign acc_addr  = addr_q;
  assign acc_wdata = wdata_q;
  assign wr_stb    = (kind_q == ACC_WRITE) ? ~lane_n_q : '0;
  assign rd_go     = (kind_q == ACC_READ) && (wake_q == WAKE_LIM);
  assign rd_lane_n = lane_n_q;

endmodule

// File: rtl/dpr_xor_bank.sv
`timescale 1ns/1ps
module dpr_xor_bank #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic [LANES-1:0]         wr_stb,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [LANES*LANE_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]        rd_addr0,
  input  logic [ADDR_W-1:0]        rd_addr1,
  output logic [LANES*LANE_W-1:0]  rd_data0,
  output logic [LANES*LANE_W-1:0]  rd_data1
);

  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  // Single-writer bank; the stored word is the XOR of all banks
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_stb[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
    end
  end

  assign rd_data0 = mem[rd_addr0];
  assign rd_data1 = mem[rd_addr1];

endmodule

// File: rtl/dpr_out_stage.sv
`timescale 1ns/1ps
module dpr_out_stage #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     rd_go,
  input  logic [LANES-1:0]         rd_lane_n,
  input  logic [LANES*LANE_W-1:0]  rd_word,
  input  logic                     oe_n,
  output logic [LANES*LANE_W-1:0]  rdata,
  output logic [LANES-1:0]         lane_drv
);

  localparam int DW = LANES * LANE_W;

  logic [LANES-1:0] drv_q;
  logic [DW-1:0]    data_q;

  // Pipeline register: state after an edge reflects the previous cycle's controls
  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q  <= '0;
      data_q <= '0;
    end else begin
      drv_q <= rd_go ? ~rd_lane_n : '0;
      if (rd_go) data_q <= rd_word;
    end
  end

  // Asynchronous output enable gates the registered drive state
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_drv[l] = drv_q[l] & ~oe_n;
    assign rdata[l*LANE_W +: LANE_W] = lane_drv[l] ? data_q[l*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/dp_lane_ram.sv
`timescale 1ns/1ps
module dp_lane_ram
  import dpr_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int LANES    = 2,
  parameter int LANE_W   = 9,
  parameter int WAKE_CYC = 2
) (
  input  logic                     a_clk,
  input  logic                     a_rst,
  input  logic                     a_cs_n,
  input  logic                     a_cs,
  input  logic                     a_rnw,
  input  logic [LANES-1:0]         a_lane_en_n,
  input  logic [ADDR_W-1:0]        a_addr,
  input  logic [LANES*LANE_W-1:0]  a_wdata,
  input  logic                     a_oe_n,
  output logic [LANES*LANE_W-1:0]  a_rdata,
  output logic [LANES-1:0]         a_lane_drv,
  input  logic                     b_clk,
  input  logic                     b_rst,
  input  logic                     b_cs_n,
  input  logic                     b_cs,
  input  logic                     b_rnw,
  input  logic [LANES-1:0]         b_lane_en_n,
  input  logic [ADDR_W-1:0]        b_addr,
  input  logic [LANES*LANE_W-1:0]  b_wdata,
  input  logic                     b_oe_n,
  output logic [LANES*LANE_W-1:0]  b_rdata,
  output logic [LANES-1:0]         b_lane_drv
);

  localparam int DW = LANES * LANE_W;
  localparam int NP = 2;

  logic              clk_v   [NP];
  logic              rst_v   [NP];
  logic              cs_n_v  [NP];
  logic              cs_v    [NP];
  logic              rnw_v   [NP];
  logic              oe_n_v  [NP];
  logic [LANES-1:0]  len_v   [NP];
  logic [ADDR_W-1:0] addr_v  [NP];
  logic [DW-1:0]     wd_v    [NP];
  logic [DW-1:0]     rd_v    [NP];
  logic [LANES-1:0]  drv_v   [NP];

  logic [ADDR_W-1:0] acc_addr  [NP];
  logic [DW-1:0]     acc_wdata [NP];
  logic [LANES-1:0]  wr_stb    [NP];
  logic              rd_go     [NP];
  logic [LANES-1:0]  rd_lane_n [NP];
  logic [DW-1:0]     word      [NP];
  logic [DW-1:0]     bank_rd   [NP][NP];

  assign clk_v[0]  = a_clk;       assign clk_v[1]  = b_clk;
  assign rst_v[0]  = a_rst;       assign rst_v[1]  = b_rst;
  assign cs_n_v[0] = a_cs_n;      assign cs_n_v[1] = b_cs_n;
  assign cs_v[0]   = a_cs;        assign cs_v[1]   = b_cs;
  assign rnw_v[0]  = a_rnw;       assign rnw_v[1]  = b_rnw;
  assign oe_n_v[0] = a_oe_n;      assign oe_n_v[1] = b_oe_n;
  assign len_v[0]  = a_lane_en_n; assign len_v[1]  = b_lane_en_n;
  assign addr_v[0] = a_addr;      assign addr_v[1] = b_addr;
  assign wd_v[0]   = a_wdata;     assign wd_v[1]   = b_wdata;

  assign a_rdata    = rd_v[0];
  assign b_rdata    = rd_v[1];
  assign a_lane_drv = drv_v[0];
  assign b_lane_drv = drv_v[1];

  for (genvar p = 0; p < NP; p++) begin : g_port
    dpr_port_ctrl #(
      .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .WAKE_CYC(WAKE_CYC)
    ) u_ctrl (
      .clk       (clk_v[p]),
      .rst       (rst_v[p]),
      .cs_n      (cs_n_v[p]),
      .cs        (cs_v[p]),
      .rnw       (rnw_v[p]),
      .lane_en_n (len_v[p]),
      .addr      (addr_v[p]),
      .wdata     (wd_v[p]),
      .acc_addr  (acc_addr[p]),
      .acc_wdata (acc_wdata[p]),
      .wr_stb    (wr_stb[p]),
      .rd_go     (rd_go[p]),
      .rd_lane_n (rd_lane_n[p])
    );

    // Bank p is written only by port p; it stores data XOR the other bank
    dpr_xor_bank #(
      .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
    ) u_bank (
      .clk      (clk_v[p]),
      .wr_stb   (wr_stb[p]),
      .wr_addr  (acc_addr[p]),
      .wr_data  (acc_wdata[p] ^ bank_rd[NP-1-p][p]),
      .rd_addr0 (acc_addr[0]),
      .rd_addr1 (acc_addr[1]),
      .rd_data0 (bank_rd[p][0]),
      .rd_data1 (bank_rd[p][1])
    );

    assign word[p] = bank_rd[0][p] ^ bank_rd[1][p];

    dpr_out_stage #(
      .LANES(LANES), .LANE_W(LANE_W)
    ) u_out (
      .clk       (clk_v[p]),
      .rst       (rst_v[p]),
      .rd_go     (rd_go[p]),
      .rd_lane_n (rd_lane_n[p]),
      .rd_word   (word[p]),
      .oe_n      (oe_n_v[p]),
      .rdata     (rd_v[p]),
      .lane_drv  (drv_v[p])
    );
  end

endmodule

// File: rtl/dpr_chk.sv
`timescale 1ns/1ps
module dpr_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cs_n,
  input logic                    cs,
  input logic                    rnw,
  input logic [LANES-1:0]        lane_en_n,
  input logic                    oe_n,
  input logic [LANES-1:0]        lane_drv,
  input logic [LANES*LANE_W-1:0] rdata
);

  logic sel;
  assign sel = !cs_n && cs;

  // R9: first edge after reset shows no driven lane
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> lane_drv == '0);

  // R1: deselected sample leaves outputs undriven after the next edge
  a_r1_desel_quiet: assert property (@(posedge clk) disable iff (rst)
    !sel |-> ##2 lane_drv == '0);

  // R6: first selected sample after a deselected one drives nothing
  a_r6_wake_gap: assert property (@(posedge clk) disable iff (rst)
    (!sel ##1 sel) |-> ##2 lane_drv == '0);

  // R10: a write access drives no lane
  a_r10_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (sel && !rnw) |-> ##2 lane_drv == '0);

  // R5: output enable high keeps every lane undriven
  a_r5_oe_off: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> lane_drv == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    // R4: disabled lane of a read is not driven
    a_r4_lane_off: assert property (@(posedge clk) disable iff (rst)
      (sel && lane_en_n[g]) |-> ##2 !lane_drv[g]);
    // R4: undriven lane presents zeros
    a_r4_zero_data: assert property (@(posedge clk) disable iff (rst)
      !lane_drv[g] |-> rdata[g*LANE_W +: LANE_W] == '0);
  end

endmodule

bind dp_lane_ram dpr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk_a (
  .clk(a_clk), .rst(a_rst), .cs_n(a_cs_n), .cs(a_cs), .rnw(a_rnw),
  .lane_en_n(a_lane_en_n), .oe_n(a_oe_n), .lane_drv(a_lane_drv), .rdata(a_rdata)
);

bind dp_lane_ram dpr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk_b (
  .clk(b_clk), .rst(b_rst), .cs_n(b_cs_n), .cs(b_cs), .rnw(b_rnw),
  .lane_en_n(b_lane_en_n), .oe_n(b_oe_n), .lane_drv(b_lane_drv), .rdata(b_rdata)
);

// File: tb/test_dp_lane_ram.sv
`timescale 1ns/1ps
module test_dp_lane_ram;

  typedef struct packed {
    int unsigned cyc;
    logic [1:0]  drv;
    logic [17:0] data;
    int unsigned req;
  } exp_t;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst   = 1'b1;
  logic [1:0] cs_n = 2'b11;
  logic [1:0] cs   = 2'b00;
  logic [1:0] rnw  = 2'b11;
  logic [1:0] oe_n = 2'b00;
  logic [1:0]  len [2];
  logic [9:0]  adr [2];
  logic [17:0] wd  [2];
  logic [17:0] rd_a, rd_b;
  logic [1:0]  drv_a, drv_b;

  int unsigned cyc_a = 0;
  int unsigned cyc_b = 0;
  int checks = 0;
  int errors = 0;
  int act [2];
  logic [17:0] sh [0:1023];
  exp_t qa [$];
  exp_t qb [$];

  always #4 clk_a = ~clk_a;                 // 125 MHz port A
  initial begin #1; forever #5 clk_b = ~clk_b; end  // unrelated port B clock

  always @(posedge clk_a) cyc_a <= cyc_a + 1;
  always @(posedge clk_b) cyc_b <= cyc_b + 1;

  dp_lane_ram i_dp_lane_ram (
    .a_clk(clk_a), .a_rst(rst), .a_cs_n(cs_n[0]), .a_cs(cs[0]), .a_rnw(rnw[0]),
    .a_lane_en_n(len[0]), .a_addr(adr[0]), .a_wdata(wd[0]), .a_oe_n(oe_n[0]),
    .a_rdata(rd_a), .a_lane_drv(drv_a),
    .b_clk(clk_b), .b_rst(rst), .b_cs_n(cs_n[1]), .b_cs(cs[1]), .b_rnw(rnw[1]),
    .b_lane_en_n(len[1]), .b_addr(adr[1]), .b_wdata(wd[1]), .b_oe_n(oe_n[1]),
    .b_rdata(rd_b), .b_lane_drv(drv_b)
  );

  task automatic check(input int req, input string what,
                       input logic [19:0] actual, input logic [19:0] expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, actual, expected);
    end
  endtask

  // Driver: one access on port p, pushes the expected output state
  task automatic op(input int p, input bit csn, input bit csh, input bit rw,
                    input logic [1:0] ln, input int a, input logic [17:0] d,
                    input int req);
    exp_t e;
    bit s;
    logic [1:0] dv;
    logic [17:0] ed;
    if (p == 0) @(posedge clk_a); else @(posedge clk_b);
    #2;
    cs_n[p] = csn; cs[p] = csh; rnw[p] = rw; len[p] = ln;
    adr[p] = a[9:0]; wd[p] = d;
    s = !csn && csh;
    act[p] = s ? ((act[p] >= 2) ? 2 : act[p] + 1) : 0;
    if (s && !rw)
      for (int l = 0; l < 2; l++) if (!ln[l]) sh[a][l*9 +: 9] = d[l*9 +: 9];
    dv = (s && rw && act[p] == 2) ? ~ln : 2'b00;
    ed = '0;
    for (int l = 0; l < 2; l++) if (dv[l]) ed[l*9 +: 9] = sh[a][l*9 +: 9];
    e.cyc  = ((p == 0) ? cyc_a : cyc_b) + 2;
    e.drv  = dv;
    e.data = ed;
    e.req  = req;
    if (p == 0) qa.push_back(e); else qb.push_back(e);
  endtask

  task automatic idle(input int p);
    op(p, 1'b0, 1'b1, 1'b1, 2'b11, 0, 18'h0, 9);
  endtask

  // Monitors: compare outputs in the cycle each item is due
  initial begin
    forever begin
      @(posedge clk_a); #3;
      while (qa.size() > 0 && qa[0].cyc <= cyc_a) begin
        exp_t e;
        e = qa.pop_front();
        check(e.req, "port A output", {drv_a, rd_a}, {e.drv, e.data});
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk_b); #3;
      while (qb.size() > 0 && qb[0].cyc <= cyc_b) begin
        exp_t e;
        e = qb.pop_front();
        check(e.req, "port B output", {drv_b, rd_b}, {e.drv, e.data});
      end
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    act[0] = 0; act[1] = 0;
    for (int p = 0; p < 2; p++) begin len[p] = 2'b11; adr[p] = '0; wd[p] = '0; end
    for (int i = 0; i < 1024; i++) sh[i] = '0;
    #50 rst = 1'b0;
    #1;
    // R9: outputs quiet out of reset
    check(9, "port A after reset", {drv_a, rd_a}, 20'h0);
    check(9, "port B after reset", {drv_b, rd_b}, 20'h0);

    // R9: two selected edges before reads can drive
    idle(0); idle(0); idle(1); idle(1);

    // R2: full write, then lane-0-only overwrite
    op(0, 0, 1, 0, 2'b00, 5, 18'h15A5A, 2);
    op(0, 0, 1, 0, 2'b00, 6, 18'h3FFFF, 10);   // R10 write drives nothing
    op(0, 0, 1, 0, 2'b10, 6, 18'h00012, 2);
    // R3: back-to-back reads of fresh writes
    op(0, 0, 1, 1, 2'b00, 5, 18'h0, 3);
    op(0, 0, 1, 1, 2'b00, 6, 18'h0, 3);        // expects 18'h3FE12
    // R4: single-lane reads
    op(0, 0, 1, 1, 2'b01, 6, 18'h0, 4);
    op(0, 0, 1, 1, 2'b10, 5, 18'h0, 4);
    // R1: both deselect encodings attempt writes
    op(0, 1, 1, 0, 2'b00, 5, 18'h00000, 1);
    op(0, 0, 0, 0, 2'b00, 5, 18'h00000, 1);
    // R6: first read after deselect undriven, second driven with old data
    op(0, 0, 1, 1, 2'b00, 5, 18'h0, 6);
    op(0, 0, 1, 1, 2'b00, 5, 18'h0, 1);

    // R5: asynchronous output enable during a steady read
    op(0, 0, 1, 1, 2'b00, 6, 18'h0, 5);
    @(posedge clk_a); @(posedge clk_a); #5;
    check(5, "drive before oe", {18'h0, drv_a}, {18'h0, 2'b11});
    oe_n[0] = 1'b1; #1;
    check(5, "oe high forces quiet", {drv_a, rd_a}, 20'h0);
    oe_n[0] = 1'b0; #0.5;
    check(5, "oe low restores", {drv_a, rd_a}, {2'b11, 18'h3FE12});
    idle(0);

    // R7: write on A, read on B; lane-1 write on B, read on A
    op(0, 0, 1, 0, 2'b00, 20, 18'h0ABCD, 7);
    idle(0);
    op(1, 0, 1, 1, 2'b00, 20, 18'h0, 7);
    op(1, 0, 1, 0, 2'b01, 21, 18'h2AA00, 7);
    idle(1); idle(1);
    op(0, 0, 1, 1, 2'b01, 21, 18'h0, 7);
    idle(0);

    // R7: simultaneous writes to distinct addresses
    fork
      op(0, 0, 1, 0, 2'b00, 30, 18'h11111, 7);
      op(1, 0, 1, 0, 2'b00, 31, 18'h22222, 7);
    join
    idle(0); idle(0); idle(1); idle(1);
    fork
      op(0, 0, 1, 1, 2'b00, 31, 18'h0, 7);
      op(1, 0, 1, 1, 2'b00, 30, 18'h0, 7);
    join
    idle(0); idle(1);

    // R8: same-address collision leaves neighbours intact
    op(0, 0, 1, 0, 2'b00, 39, 18'h0F0F0, 8);
    op(0, 0, 1, 0, 2'b00, 41, 18'h30303, 8);
    idle(0); idle(0); idle(1);
    fork
      op(0, 0, 1, 0, 2'b00, 40, 18'h3FFFF, 8);
      op(1, 0, 1, 0, 2'b00, 40, 18'h00001, 8);
    join
    idle(0); idle(0); idle(1); idle(1);
    fork
      op(0, 0, 1, 1, 2'b00, 39, 18'h0, 8);
      op(1, 0, 1, 1, 2'b00, 41, 18'h0, 8);
    join
    idle(0); idle(1);

    repeat (6) @(posedge clk_b);
    #1;
    // R3: every expected result was observed
    check(3, "pending results", 20'(qa.size() + qb.size()), 20'h0);
    summary();
    $finish;
  end

endmodule